// File: doc/BRIEF.md
# Dual-Slot Instruction Packet Dispatcher

This block accepts one 32-bit instruction word at a time and turns it into one or two issues on a downstream execute port. The two most significant bits of the word select its format. Two of the formats hold two 15-bit short operations that run one after the other, each in a fixed order. A third format holds two short operations that run together. The fourth format holds one long operation that takes up the whole 30-bit payload.

Packets arrive on a valid/ready input. While a packet is still being issued, the input is held off. Each issue is offered on the output port, and the downstream stage accepts it by raising `out_ready`. When an issue is stalled, the dispatcher keeps every output value unchanged until the issue is accepted. A done strobe marks the accepted issue that completes a packet. In that same cycle the next packet may be taken, so packets can follow each other with no idle cycle between them.

Top module: `pkt_dispatch`

## Requirements
- R1: After reset, `out_valid_a`, `out_valid_b` and `out_done` are 0 and `in_ready` is 1.
- R2: Format 2'b01 (bits 31:30) gives two issues on slot A, both with `out_valid_b` = 0. The first issue carries bits 29:15 of the word and the second carries bits 14:0. Each short operation is zero-extended to 30 bits on `out_op_a`.
- R3: Format 2'b10 gives two issues on slot A, both with `out_valid_b` = 0. The first issue carries bits 14:0 of the word and the second carries bits 29:15, each zero-extended.
- R4: Format 2'b00 gives one issue with both slots valid. Slot A carries bits 29:15, zero-extended. Slot B carries bits 14:0.
- R5: Format 2'b11 gives one issue with `out_long` = 1. `out_op_a` carries bits 29:0 and `out_valid_b` = 0. For every other format, `out_long` is 0.
- R6: While a packet is held, `in_ready` is 0. The one exception is the cycle in which the packet's last issue is accepted: there `in_ready` is 1, and a word offered in that cycle is issued in the next cycle.
- R7: While an issue is offered and `out_ready` is 0, all issue outputs keep their values in the next cycle.
- R8: `out_done` is 1 only in the cycle in which the last issue of a packet is accepted. It is 0 on every other cycle, including stalled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Packet word offered |
| in_ready | output | 1 | Dispatcher can take a word |
| in_word | input | 32 | Packet word: format in bits 31:30, payload below |
| out_ready | input | 1 | Downstream accepts the current issue |
| out_valid_a | output | 1 | Slot A holds an operation |
| out_op_a | output | 30 | Slot A operation (short ops zero-extended, or the long payload) |
| out_valid_b | output | 1 | Slot B holds an operation (parallel format only) |
| out_op_b | output | 15 | Slot B operation |
| out_long | output | 1 | Slot A holds a long operation |
| out_done | output | 1 | Last issue of the packet accepted this cycle |

## Verification
The bench sweeps all four formats against payloads that put distinct values in each half of the word, and it repeats the sweep with stall patterns on `out_ready`.

- **Swapped halves or order.** A design that swaps the halves, or that mixes up the two sequential orders, would issue the wrong half first.
- **Broken stall.** A design that advances or changes its outputs during a stall would break the stability check.
- **Premature strobe.** A design that raises done or ready after the first of two issues would be caught at that first issue.
- **Lost back-to-back packet.** In the back-to-back case, a word offered during the final accepted issue must appear at once. A design that dropped this word, or that needed an idle cycle, would show the wrong issue there.

// File: rtl/dsp_pkg.sv
// Package: shared widths and format codes for the packet dispatcher.
// Assumes a word of two equal short slots plus a two-bit format field on top.
package dsp_pkg;
    localparam int OP_W   = 15;
    localparam int PAY_W  = 2 * OP_W;
    localparam int WORD_W = PAY_W + 2;

    typedef enum logic [1:0] {
        FMT_PAR  = 2'b00,
        FMT_LTOR = 2'b01,
        FMT_RTOL = 2'b10,
        FMT_LONG = 2'b11
    } fmt_e;
endpackage

// File: rtl/dsp_decode.sv
// Module: dsp_decode
// Turns a held packet word and the issue phase into the slot contents for
// this issue. It is pure combinational logic. It assumes phase is 0 on the
// first issue and 1 on the second, and that only sequential formats reach
// phase 1.
module dsp_decode
    import dsp_pkg::*;
#(
    parameter int SW = OP_W
) (
    input  logic [2*SW+1:0] word,
    input  logic            phase,
    output logic [2*SW-1:0] op_a,
    output logic [SW-1:0]   op_b,
    output logic            vb,
    output logic            is_long,
    output logic            last
);
    localparam int PW = 2 * SW;

    logic [1:0]    fmt;
    logic [SW-1:0] left_op;
    logic [SW-1:0] right_op;

    assign fmt      = word[PW+1:PW];
    assign left_op  = word[PW-1:SW];
    assign right_op = word[SW-1:0];

    // Pick the slot contents from the format and the phase.
    always_comb begin
        op_a    = '0;
        op_b    = '0;
        vb      = 1'b0;
        is_long = 1'b0;
        last    = 1'b1;
        unique case (fmt)
            FMT_PAR: begin
                op_a = {{SW{1'b0}}, left_op};
                op_b = right_op;
                vb   = 1'b1;
            end
            FMT_LTOR: begin
                op_a = {{SW{1'b0}}, (phase ? right_op : left_op)};
                last = phase;
            end
            FMT_RTOL: begin
                op_a = {{SW{1'b0}}, (phase ? left_op : right_op)};
                last = phase;
            end
            default: begin
                op_a    = word[PW-1:0];
                is_long = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dsp_ctrl.sv
// Module: dsp_ctrl
// Holds the current packet and tracks which issue it is on. It takes a new
// word when it is idle, or in the same cycle that the last issue of the
// current packet is accepted. It assumes `last` comes from decoding the held
// word.
module dsp_ctrl #(
    parameter int WW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [WW-1:0] in_word,
    input  logic          out_ready,
    input  logic          last,
    output logic          in_ready,
    output logic          busy,
    output logic          phase,
    output logic [WW-1:0] word_q,
    output logic          fire
);
    logic take;

    // An issue is accepted when one is held and downstream is ready.
    assign fire     = busy & out_ready;
    assign in_ready = ~busy | (fire & last);
    assign take     = in_valid & in_ready;

    // Packet holding register and issue phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            phase  <= 1'b0;
            word_q <= '0;
        end else if (take) begin
            busy   <= 1'b1;
            phase  <= 1'b0;
            word_q <= in_word;
        end else if (fire) begin
            if (last) begin
                busy  <= 1'b0;
                phase <= 1'b0;
            end else begin
                phase <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pkt_dispatch.sv
// Module: pkt_dispatch (top)
// Dispatches a two-slot instruction word as one or two issues, in the order
// its format field selects. It assumes the downstream port takes one issue
// per cycle in which out_ready is high while an issue is offered.
module pkt_dispatch
    import dsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic              out_ready,
    output logic              out_valid_a,
    output logic [PAY_W-1:0]  out_op_a,
    output logic              out_valid_b,
    output logic [OP_W-1:0]   out_op_b,
    output logic              out_long,
    output logic              out_done
);
    logic              busy;
    logic              phase;
    logic              fire;
    logic              last;
    logic              vb;
    logic [WORD_W-1:0] word_q;

    dsp_ctrl #(.WW(WORD_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .out_ready (out_ready),
        .last      (last),
        .in_ready  (in_ready),
        .busy      (busy),
        .phase     (phase),
        .word_q    (word_q),
        .fire      (fire)
    );

    dsp_decode #(.SW(OP_W)) u_dec (
        .word    (word_q),
        .phase   (phase),
        .op_a    (out_op_a),
        .op_b    (out_op_b),
        .vb      (vb),
        .is_long (out_long),
        .last    (last)
    );

    // Qualify the slot flags and the done strobe with the held state.
    assign out_valid_a = busy;
    assign out_valid_b = busy & vb;
    assign out_done    = fire & last;
endmodule

// File: rtl/pkt_dispatch_chk.sv
// Module: pkt_dispatch_chk
// Checks the port-level protocol of pkt_dispatch. It is bound to every
// instance of the top module.
module pkt_dispatch_chk
    import dsp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_ready,
    input logic             out_valid_a,
    input logic [PAY_W-1:0] out_op_a,
    input logic             out_valid_b,
    input logic [OP_W-1:0]  out_op_b,
    input logic             out_long,
    input logic             out_done
);
    // R7: a stalled issue is held unchanged.
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_a && !out_ready) |=> (out_valid_a && $stable(out_op_a)
            && $stable(out_op_b) && $stable(out_valid_b) && $stable(out_long)));

    // R8: done only on an accepted issue.
    a_r8_done_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (out_valid_a && out_ready));

    // R6: input stays closed while a packet is pending and not finishing.
    a_r6_ready_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_a && !out_done) |-> !in_ready);

    // R4: slot B is valid only together with slot A, and never for a long op.
    a_r4_slot_b_pairing: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_b |-> (out_valid_a && !out_long));

    // R6: the last accepted issue always reopens the input.
    a_r6_reopen_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> in_ready);
endmodule

bind pkt_dispatch pkt_dispatch_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .out_ready   (out_ready),
    .out_valid_a (out_valid_a),
    .out_op_a    (out_op_a),
    .out_valid_b (out_valid_b),
    .out_op_b    (out_op_b),
    .out_long    (out_long),
    .out_done    (out_done)
);

// File: tb/pkt_dispatch_tb.sv
module pkt_dispatch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        out_ready = 1'b0;
    logic        out_valid_a;
    logic [29:0] out_op_a;
    logic        out_valid_b;
    logic [14:0] out_op_b;
    logic        out_long;
    logic        out_done;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    pkt_dispatch u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_word     (in_word),
        .out_ready   (out_ready),
        .out_valid_a (out_valid_a),
        .out_op_a    (out_op_a),
        .out_valid_b (out_valid_b),
        .out_op_b    (out_op_b),
        .out_long    (out_long),
        .out_done    (out_done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Number of issues a packet takes, from its format.
    function automatic int n_issue(input logic [31:0] w);
        return (w[31:30] == 2'b01 || w[31:30] == 2'b10) ? 2 : 1;
    endfunction

    // Expected slot A contents for issue k.
    function automatic logic [29:0] exp_a(input logic [31:0] w, input int k);
        case (w[31:30])
            2'b00:   return {15'd0, w[29:15]};
            2'b01:   return (k == 0) ? {15'd0, w[29:15]} : {15'd0, w[14:0]};
            2'b10:   return (k == 0) ? {15'd0, w[14:0]} : {15'd0, w[29:15]};
            default: return w[29:0];
        endcase
    endfunction

    // Requirement tag that covers each format.
    function automatic string tag(input logic [31:0] w);
        case (w[31:30])
            2'b00:   return "R4";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R5";
        endcase
    endfunction

    task automatic run_pkt(input logic [31:0] w, input int stall_mask);
        int          n = n_issue(w);
        int          k = 0;
        int          cyc = 0;
        bit          have_prev = 0;
        logic [29:0] pa = '0;
        logic [14:0] pb = '0;
        string       t = tag(w);

        @(negedge clk);
        in_valid = 1'b1;
        in_word = w;
        out_ready = 1'b0;
        #1;
        chk(in_ready == 1'b1, "R6 idle ready", 64'(in_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        while (k < n && cyc < 24) begin
            out_ready = !stall_mask[cyc];
            #1;
            chk(out_valid_a == 1'b1, t, 64'(out_valid_a), 64'd1);
            if (have_prev) begin
                // R7: the stalled issue must be unchanged.
                chk(out_op_a == pa && out_op_b == pb, "R7 hold",
                    {19'd0, out_op_a, out_op_b}, {19'd0, pa, pb});
            end
            if (out_ready) begin
                chk(out_op_a == exp_a(w, k), t, 64'(out_op_a), 64'(exp_a(w, k)));
                chk(out_valid_b == (w[31:30] == 2'b00), t, 64'(out_valid_b),
                    64'(w[31:30] == 2'b00));
                if (w[31:30] == 2'b00)
                    chk(out_op_b == w[14:0], "R4 slot B", 64'(out_op_b), 64'(w[14:0]));
                chk(out_long == (w[31:30] == 2'b11), "R5 long flag", 64'(out_long),
                    64'(w[31:30] == 2'b11));
                chk(out_done == (k == n - 1), "R8 done", 64'(out_done), 64'(k == n - 1));
                chk(in_ready == (k == n - 1), "R6 ready", 64'(in_ready), 64'(k == n - 1));
                k++;
                have_prev = 0;
            end else begin
                chk(out_done == 1'b0, "R8 no done on stall", 64'(out_done), 64'd0);
                pa = out_op_a;
                pb = out_op_b;
                have_prev = 1;
            end
            cyc++;
            @(posedge clk);
            @(negedge clk);
        end
        out_ready = 1'b0;
        #1;
        chk(out_valid_a == 1'b0 && out_done == 1'b0, "R8 idle after packet",
            64'(out_valid_a), 64'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [31:0] w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state.
        chk(out_valid_a == 0 && out_valid_b == 0 && out_done == 0, "R1 outputs",
            {61'd0, out_valid_a, out_valid_b, out_done}, 64'd0);
        chk(in_ready == 1'b1, "R1 ready", 64'(in_ready), 64'd1);

        // Sweep formats, payloads and stall patterns.
        for (int f = 0; f < 4; f++) begin
            for (int p = 0; p < 6; p++) begin
                for (int s = 0; s < 4; s++) begin
                    w = {f[1:0], 15'(p * 4663 + 17), 15'(p * 911 + 5 + s)};
                    run_pkt(w, (s == 0) ? 0 : (s == 1) ? 32'h1 : (s == 2) ? 32'h6 : 32'h2D);
                end
            end
        end

        // R6: back-to-back, a parallel packet followed at once by a long packet.
        @(negedge clk);
        in_valid = 1'b1;
        in_word = {2'b00, 15'h1234, 15'h0ABC};
        @(posedge clk);
        @(negedge clk);
        in_word = {2'b11, 30'h2345_6789};
        out_ready = 1'b1;
        #1;
        chk(in_ready == 1'b1 && out_done == 1'b1, "R6 back-to-back ready",
            {62'd0, in_ready, out_done}, 64'd3);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(out_valid_a == 1'b1 && out_long == 1'b1 && out_op_a == 30'h2345_6789,
            "R6 back-to-back issue", 64'(out_op_a), 64'h2345_6789);
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        #1;
        chk(out_valid_a == 1'b0, "R6 drained", 64'(out_valid_a), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule